// File: doc/BRIEF.md
# Scan-Accessed Debug Register Bank

This block sits behind one data register of a test access port. It gives an external debugger read and write access to a small bank of 32-bit debug registers. Every scan moves a 38-bit frame through a shift register. Capture loads the result of the previous read request into the data field, shift moves the frame one bit per clock, and update acts on the frame that was shifted in. A read is therefore pipelined: its value comes out during the following scan.

The bank holds a 6-bit debug control register and a 5-bit debug status view taken from the core. It also holds a vector-catch register, two watch units of six words each, and a two-way mailbox for passing words between the debugger and the processor. On the core side the mailbox has two valid/ready word streams.

- **Host-to-core stream.** `h2c_valid` is high while a debugger word is waiting. The word leaves on any clock where `h2c_valid` and `h2c_ready` are both high, and `h2c_data` holds steady until then.
- **Core-to-host stream.** `c2h_ready` is low while an earlier core word has not yet been read by the debugger. A word is accepted only on a clock where `c2h_valid` and `c2h_ready` are both high. The core may hold `c2h_valid` for as long as it needs to.

Top module: `dbg_scan_bank`

## Requirements
- R1: The frame goes in least significant bit first: 32 data bits, then a 5-bit address, then a write flag. After 38 shift clocks, an update with the flag at 1 stores the data field into the addressed register.
- R2: An update with the write flag at 0 latches the addressed register. The next capture loads that value into the data field, and the value leaves on `tdo` during the next scan. The bit of `tdo` before each shift clock is the next data bit, LSB first.
- R3: Debug control is at address 0x00. It is 6 bits wide, resets to 0x10 (bit 4 is the monitor-mode enable), and is writable. `dbg_ctrl` shows its value, and reads return it zero-extended.
- R4: Debug status is at address 0x01. A read returns the `dbg_status` input zero-extended, and writes have no effect.
- R5: Comms control is at address 0x04. Its read value is bit 0 = host-word-pending flag, bit 1 = core-word-pending flag, bits 27:2 zero, and bits 31:28 the VERSION parameter (default 2). Writes to it are ignored.
- R6: A debugger write to comms data (address 0x05) stores the word and sets the host-word-pending flag, which drives `h2c_valid`. A core handshake (`h2c_valid` and `h2c_ready` both high) clears the flag on that clock edge.
- R7: A debugger write to comms data while the host-word-pending flag is set replaces the waiting word, and the flag stays set.
- R8: `c2h_ready` is the inverse of the core-word-pending flag. A core handshake stores `c2h_data` and sets the flag. While the flag is set, `c2h_valid` has no effect.
- R9: A debugger read of comms data returns the core word and clears the core-word-pending flag. A read of comms control leaves both flags unchanged.
- R10: The watch registers at 0x08–0x0D and 0x10–0x15 hold full 32-bit words. Vector catch at 0x02 keeps its low 8 bits and drives `vcatch`. All of them read back what was written.
- R11: Any other address reads as zero and ignores writes.
- R12: Two events on one clock are defined as follows. A debugger write to comms data on the same edge as a core take leaves the flag set with the new word. A debugger read of comms data on the same edge as a core push returns the old word and leaves the core-word-pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Load the last read result into the frame |
| shift_en | input | 1 | Shift the frame one bit toward `tdo` |
| update_en | input | 1 | Act on the shifted-in frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| dbg_status | input | 5 | Core status bits shown at address 0x01 |
| dbg_ctrl | output | 6 | Debug control register value |
| vcatch | output | 8 | Vector-catch register value |
| wu_cfg | output | 384 | Watch-unit words; unit u, word k at bits [(u*6+k)*32 +: 32] |
| h2c_valid | output | 1 | Host word waiting for the core |
| h2c_ready | input | 1 | Core accepts the host word |
| h2c_data | output | 32 | Host word |
| c2h_valid | input | 1 | Core offers a word |
| c2h_ready | output | 1 | Mailbox can take a core word |
| c2h_data | input | 32 | Core word |

## Verification
The risky moments are when a scan update and a core-side handshake hit the same clock edge. One case is a debugger write to comms data while the core takes the waiting word. The other is a debugger read of comms data while the core pushes a new word. The bench raises `h2c_ready` or `c2h_valid` exactly on the update cycle of such a scan. A behavioural model decides the flags, the waiting word and the pipelined read result, and the bench compares against it on every clock and again on the scan that follows.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int FRAME_W = WORD_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] ADR_DCTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_DSTAT  = 5'h01;
  localparam logic [ADDR_W-1:0] ADR_VCATCH = 5'h02;
  localparam logic [ADDR_W-1:0] ADR_CCTRL  = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_CDATA  = 5'h05;

  localparam int WU_BASE   = 8;
  localparam int WU_STRIDE = 8;
  localparam int WU_REGS   = 6;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dsb_shifter.sv
module dsb_shifter
  import dsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              tdi,
  input  logic [WORD_W-1:0] cap_word,
  output logic              tdo,
  output frame_t            frame
);
  frame_t sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (capture_en) begin
      sr.wr   <= 1'b0;
      sr.addr <= '0;
      sr.data <= cap_word;
    end else if (shift_en) begin
      sr <= frame_t'({tdi, sr[FRAME_W-1:1]});
    end
  end

  assign tdo   = sr[0];
  assign frame = sr;

  // R2
  cap_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (sr.data == $past(cap_word)));
endmodule

// File: rtl/dsb_mailbox.sv
module dsb_mailbox
  import dsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_wr,
  input  logic [WORD_W-1:0] dbg_word,
  input  logic              dbg_take,
  output logic              h2c_valid,
  input  logic              h2c_ready,
  output logic [WORD_W-1:0] h2c_data,
  input  logic              c2h_valid,
  output logic              c2h_ready,
  input  logic [WORD_W-1:0] c2h_data,
  output logic              r_flag,
  output logic              w_flag,
  output logic [WORD_W-1:0] c2h_word
);
  logic [WORD_W-1:0] h2c_q;
  logic              core_take;
  logic              core_push;

  assign core_take = r_flag && h2c_ready;
  assign core_push = c2h_valid && !w_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_flag <= 1'b0;
      h2c_q  <= '0;
    end else if (dbg_wr) begin
      r_flag <= 1'b1;
      h2c_q  <= dbg_word;
    end else if (core_take) begin
      r_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_flag   <= 1'b0;
      c2h_word <= '0;
    end else if (core_push) begin
      w_flag   <= 1'b1;
      c2h_word <= c2h_data;
    end else if (dbg_take) begin
      w_flag   <= 1'b0;
    end
  end

  assign h2c_valid = r_flag;
  assign h2c_data  = h2c_q;
  assign c2h_ready = !w_flag;

  // R6
  h2c_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h2c_valid && h2c_ready && !dbg_wr) |=> !h2c_valid);
  // R7
  h2c_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr && h2c_valid) |=> (h2c_valid && h2c_data == $past(dbg_word)));
  // R8
  c2h_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_valid && c2h_ready) |=> !c2h_ready);
  // R9
  c2h_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_take && !c2h_ready) |=> c2h_ready);
endmodule

// File: rtl/dsb_regfile.sv
module dsb_regfile
  import dsb_pkg::*;
#(
  parameter int          NUM_WU   = 2,
  parameter int          CTRL_W   = 6,
  parameter int          STAT_W   = 5,
  parameter int          VC_W     = 8,
  parameter logic [5:0]  CTRL_RST = 6'h10,
  parameter logic [3:0]  VERSION  = 4'h2,
  localparam int         WU_N     = NUM_WU * WU_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_word,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [WORD_W-1:0]      rd_word,
  input  logic [STAT_W-1:0]      dbg_status,
  input  logic                   r_flag,
  input  logic                   w_flag,
  input  logic [WORD_W-1:0]      c2h_word,
  output logic [CTRL_W-1:0]      dbg_ctrl,
  output logic [VC_W-1:0]        vcatch,
  output logic [WU_N*WORD_W-1:0] wu_cfg
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [VC_W-1:0]   vc_q;
  logic [WORD_W-1:0] wu_q [WU_N];

  function automatic logic [ADDR_W-1:0] wu_addr(input int idx);
    return ADDR_W'(WU_BASE + (idx / WU_REGS) * WU_STRIDE + (idx % WU_REGS));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST[CTRL_W-1:0];
      vc_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_DCTRL)  ctrl_q <= wr_word[CTRL_W-1:0];
      if (wr_addr == ADR_VCATCH) vc_q   <= wr_word[VC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WU_N; i++) wu_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < WU_N; i++)
        if (wr_addr == wu_addr(i)) wu_q[i] <= wr_word;
    end
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADR_DCTRL:  rd_word = WORD_W'(ctrl_q);
      ADR_DSTAT:  rd_word = WORD_W'(dbg_status);
      ADR_VCATCH: rd_word = WORD_W'(vc_q);
      ADR_CCTRL:  rd_word = {VERSION, {(WORD_W-6){1'b0}}, w_flag, r_flag};
      ADR_CDATA:  rd_word = c2h_word;
      default: begin
        for (int i = 0; i < WU_N; i++)
          if (rd_addr == wu_addr(i)) rd_word = wu_q[i];
      end
    endcase
  end

  generate
    for (genvar g = 0; g < WU_N; g++) begin : g_wu_out
      assign wu_cfg[g*WORD_W +: WORD_W] = wu_q[g];
    end
  endgenerate

  assign dbg_ctrl = ctrl_q;
  assign vcatch   = vc_q;

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADR_DCTRL) |=> $stable(dbg_ctrl));
  // R10
  vc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_VCATCH) |=> (vcatch == $past(wr_word[VC_W-1:0])));
endmodule

// File: rtl/dbg_scan_bank.sv
module dbg_scan_bank
  import dsb_pkg::*;
#(
  parameter int         NUM_WU   = 2,
  parameter int         CTRL_W   = 6,
  parameter int         STAT_W   = 5,
  parameter int         VC_W     = 8,
  parameter logic [5:0] CTRL_RST = 6'h10,
  parameter logic [3:0] VERSION  = 4'h2,
  localparam int        CFG_W    = NUM_WU * WU_REGS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  output logic              tdo,
  input  logic [STAT_W-1:0] dbg_status,
  output logic [CTRL_W-1:0] dbg_ctrl,
  output logic [VC_W-1:0]   vcatch,
  output logic [CFG_W-1:0]  wu_cfg,
  output logic              h2c_valid,
  input  logic              h2c_ready,
  output logic [WORD_W-1:0] h2c_data,
  input  logic              c2h_valid,
  output logic              c2h_ready,
  input  logic [WORD_W-1:0] c2h_data
);
  frame_t            frame;
  logic [WORD_W-1:0] read_buf;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] c2h_word;
  logic              r_flag, w_flag;
  logic              upd_wr, upd_rd, hit_cdata;

  assign upd_wr    = update_en && frame.wr;
  assign upd_rd    = update_en && !frame.wr;
  assign hit_cdata = (frame.addr == ADR_CDATA);

  dsb_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .tdi        (tdi),
    .cap_word   (read_buf),
    .tdo        (tdo),
    .frame      (frame)
  );

  dsb_regfile #(
    .NUM_WU   (NUM_WU),
    .CTRL_W   (CTRL_W),
    .STAT_W   (STAT_W),
    .VC_W     (VC_W),
    .CTRL_RST (CTRL_RST),
    .VERSION  (VERSION)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (upd_wr),
    .wr_addr    (frame.addr),
    .wr_word    (frame.data),
    .rd_addr    (frame.addr),
    .rd_word    (rd_word),
    .dbg_status (dbg_status),
    .r_flag     (r_flag),
    .w_flag     (w_flag),
    .c2h_word   (c2h_word),
    .dbg_ctrl   (dbg_ctrl),
    .vcatch     (vcatch),
    .wu_cfg     (wu_cfg)
  );

  dsb_mailbox u_mbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_wr    (upd_wr && hit_cdata),
    .dbg_word  (frame.data),
    .dbg_take  (upd_rd && hit_cdata),
    .h2c_valid (h2c_valid),
    .h2c_ready (h2c_ready),
    .h2c_data  (h2c_data),
    .c2h_valid (c2h_valid),
    .c2h_ready (c2h_ready),
    .c2h_data  (c2h_data),
    .r_flag    (r_flag),
    .w_flag    (w_flag),
    .c2h_word  (c2h_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      read_buf <= '0;
    else if (upd_rd) read_buf <= rd_word;
  end

  // R12
  take_push_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_rd && hit_cdata && c2h_valid && c2h_ready) |=> !c2h_ready);
endmodule

// File: tb/dbg_scan_bank_tb.sv
module dbg_scan_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture_en = 0, shift_en = 0, update_en = 0, tdi = 0;
  logic tdo;
  logic [4:0]   dbg_status = 5'h15;
  logic [5:0]   dbg_ctrl;
  logic [7:0]   vcatch;
  logic [383:0] wu_cfg;
  logic         h2c_valid, c2h_ready;
  logic         h2c_ready = 0, c2h_valid = 0;
  logic [31:0]  h2c_data;
  logic [31:0]  c2h_data = '0;

  int checks = 0, errs = 0;
  bit running = 0;

  always #10 clk = ~clk;

  dbg_scan_bank u_dut (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdi(tdi), .tdo(tdo), .dbg_status(dbg_status),
    .dbg_ctrl(dbg_ctrl), .vcatch(vcatch), .wu_cfg(wu_cfg),
    .h2c_valid(h2c_valid), .h2c_ready(h2c_ready), .h2c_data(h2c_data),
    .c2h_valid(c2h_valid), .c2h_ready(c2h_ready), .c2h_data(c2h_data)
  );

  // behavioural model
  logic        m_R, m_W;
  logic [31:0] m_h2c, m_c2h, m_readbuf;
  logic [5:0]  m_ctrl;
  logic [7:0]  m_vc;
  logic [31:0] m_wu [32];
  logic        f_wr;
  logic [4:0]  f_addr;
  logic [31:0] f_data;

  function automatic bit is_wu(input logic [4:0] a);
    return (a >= 5'h08 && a <= 5'h0D) || (a >= 5'h10 && a <= 5'h15);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return {26'd0, m_ctrl};
      5'h01: return {27'd0, dbg_status};
      5'h02: return {24'd0, m_vc};
      5'h04: return {4'h2, 26'd0, m_W, m_R};
      5'h05: return m_c2h;
      default: return is_wu(a) ? m_wu[a] : 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic nR, nW;
    if (!rst_n) begin
      m_R = 0; m_W = 0; m_h2c = 0; m_c2h = 0; m_readbuf = 0;
      m_ctrl = 6'h10; m_vc = 0;
      for (int i = 0; i < 32; i++) m_wu[i] = 0;
    end else begin
      nR = m_R; nW = m_W;
      if (m_R && h2c_ready) nR = 0;
      if (update_en) begin
        if (f_wr) begin
          if (f_addr == 5'h00) m_ctrl = f_data[5:0];
          else if (f_addr == 5'h02) m_vc = f_data[7:0];
          else if (f_addr == 5'h05) begin m_h2c = f_data; nR = 1; end
          else if (is_wu(f_addr)) m_wu[f_addr] = f_data;
        end else begin
          m_readbuf = m_read(f_addr);
          if (f_addr == 5'h05) nW = 0;
        end
      end
      if (c2h_valid && !m_W) begin nW = 1; m_c2h = c2h_data; end
      m_R = nR; m_W = nW;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (running) begin
      chk({31'd0, h2c_valid}, {31'd0, m_R}, "R6 h2c_valid");
      chk({31'd0, c2h_ready}, {31'd0, !m_W}, "R8 c2h_ready");
      chk({26'd0, dbg_ctrl}, {26'd0, m_ctrl}, "R3 dbg_ctrl");
      chk({24'd0, vcatch}, {24'd0, m_vc}, "R10 vcatch");
      if (m_R) chk(h2c_data, m_h2c, "R7 h2c_data");
    end
  end

  task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input bit race_take, input bit race_push,
                      output logic [31:0] got, output logic [31:0] exp);
    logic [37:0] fr;
    fr = {wr, a, d};
    @(negedge clk);
    exp = m_readbuf;
    capture_en = 1;
    @(negedge clk);
    capture_en = 0;
    for (int i = 0; i < 38; i++) begin
      if (i < 32) got[i] = tdo;
      shift_en = 1;
      tdi = fr[i];
      @(negedge clk);
    end
    shift_en = 0;
    f_wr = wr; f_addr = a; f_data = d;
    update_en = 1;
    if (race_take) h2c_ready = 1;
    if (race_push) c2h_valid = 1;
    @(negedge clk);
    update_en = 0;
    h2c_ready = 0;
    c2h_valid = 0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] g, e;
    scan(1'b1, a, d, 0, 0, g, e);
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [31:0] want, input string tag);
    logic [31:0] g, e;
    scan(1'b0, a, 32'd0, 0, 0, g, e);
    scan(1'b0, 5'h04, 32'd0, 0, 0, g, e);
    chk(g, want, tag);
    chk(g, e, {tag, " model"});
  endtask

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] g, e, prev;
    f_wr = 0; f_addr = 0; f_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({26'd0, dbg_ctrl}, 32'h10, "R3 reset");
    chk({31'd0, h2c_valid}, 32'd0, "R6 reset");
    chk({31'd0, c2h_ready}, 32'd1, "R8 reset");
    running = 1;

    rd_reg(5'h00, 32'h10, "R3 read reset value");
    wr_reg(5'h00, 32'hFFFF_FFE5);
    chk({26'd0, dbg_ctrl}, 32'h25, "R3 write");
    rd_reg(5'h00, 32'h25, "R3 readback");

    // R1 / R10: watch registers, then a pipelined read chain (R2)
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 6; k++)
        wr_reg(5'(8 + u*8 + k), 32'hA500_0000 ^ ((8 + u*8 + k) * 32'h0101_0101));
    prev = 32'hx;
    for (int n = 0; n < 13; n++) begin
      int a = (n < 12) ? (8 + (n/6)*8 + (n%6)) : 4;
      scan(1'b0, 5'(a), 32'd0, 0, 0, g, e);
      if (n > 0) begin
        chk(g, prev, "R1 R2 R10 pipelined watch read");
        chk(g, e, "R2 model");
      end
      prev = 32'hA500_0000 ^ (a * 32'h0101_0101);
    end

    wr_reg(5'h02, 32'hDEAD_BEEF);
    chk({24'd0, vcatch}, 32'hEF, "R10 vcatch port");
    rd_reg(5'h02, 32'hEF, "R10 vcatch read");

    wr_reg(5'h01, 32'hFFFF_FFFF);
    rd_reg(5'h01, 32'h15, "R4 status");

    foreach (g[i]) if (i < 5) begin
      logic [4:0] ua;
      ua = (i == 0) ? 5'h03 : (i == 1) ? 5'h06 : (i == 2) ? 5'h0E : (i == 3) ? 5'h16 : 5'h1F;
      wr_reg(ua, 32'hFFFF_FFFF);
      rd_reg(ua, 32'd0, "R11 unmapped");
    end

    wr_reg(5'h04, 32'hFFFF_FFFF);
    rd_reg(5'h04, 32'h2000_0000, "R5 comms control idle");

    // host-to-core
    wr_reg(5'h05, 32'h1111_1111);
    chk({31'd0, h2c_valid}, 32'd1, "R6 set");
    rd_reg(5'h04, 32'h2000_0001, "R5 R6 flag visible");
    wr_reg(5'h05, 32'h2222_2222);
    chk(h2c_data, 32'h2222_2222, "R7 overwrite");
    chk({31'd0, h2c_valid}, 32'd1, "R7 still pending");
    h2c_ready = 1;
    @(negedge clk);
    h2c_ready = 0;
    chk({31'd0, h2c_valid}, 32'd0, "R6 taken");

    // same-edge write and take
    wr_reg(5'h05, 32'h3333_3333);
    scan(1'b1, 5'h05, 32'h4444_4444, 1, 0, g, e);
    chk({31'd0, h2c_valid}, 32'd1, "R12 write beats take");
    chk(h2c_data, 32'h4444_4444, "R12 new word");
    h2c_ready = 1;
    @(negedge clk);
    h2c_ready = 0;

    // core-to-host
    c2h_data = 32'h5555_5555; c2h_valid = 1;
    @(negedge clk);
    c2h_valid = 0;
    chk({31'd0, c2h_ready}, 32'd0, "R8 push sets pending");
    c2h_data = 32'h6666_6666; c2h_valid = 1;
    @(negedge clk);
    c2h_valid = 0;
    rd_reg(5'h04, 32'h2000_0002, "R9 control read no side effect");
    chk({31'd0, c2h_ready}, 32'd0, "R9 still pending");
    scan(1'b0, 5'h05, 32'd0, 0, 0, g, e);
    chk({31'd0, c2h_ready}, 32'd1, "R9 data read clears");
    scan(1'b0, 5'h04, 32'd0, 0, 0, g, e);
    chk(g, 32'h5555_5555, "R9 word returned; R8 blocked push ignored");

    // same-edge read and push
    c2h_data = 32'h7777_7777;
    scan(1'b0, 5'h05, 32'd0, 0, 1, g, e);
    chk({31'd0, c2h_ready}, 32'd0, "R12 push survives read");
    scan(1'b0, 5'h05, 32'd0, 0, 0, g, e);
    chk(g, 32'h5555_5555, "R12 old word returned");
    scan(1'b0, 5'h04, 32'd0, 0, 0, g, e);
    chk(g, 32'h7777_7777, "R12 new word next");
    chk(g, e, "R2 model");

    running = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule